// File: doc/BRIEF.md
# I/O Controller Register File

This block is the processor-facing register file of a router's I/O controller, built for the small-chassis configuration. A host issues single-cycle strobes on a plain read/write bus that carries a word offset. The block answers with fixed identification and status words. It also builds an active-low module-presence word from per-slot present inputs and reports per-slot bytes of a network interrupt status vector that is stored outside the block. It holds an 8-bit I/O mask register, and it drives two bit-banged serial EEPROM pin sets.

Two interrupt sources, management and external, are held as pending requests. A read of each source's acknowledge register returns zero and clears that request. A write to the module EEPROM register also latches a two-bit slot select, which picks the module whose EEPROM is attached.

A small bus state machine sequences reads. It has two states, ST_IDLE and ST_RESP. The transition TR_ACCEPT moves ST_IDLE or ST_RESP to ST_RESP on a read strobe. The transition TR_RETIRE moves ST_RESP back to ST_IDLE when no read strobe is present. The transition TR_HOLD keeps ST_IDLE in place when no read strobe is present. Writes never leave ST_IDLE and finish in their strobe cycle.

Top module: `ioc_regfile`

## Requirements
- R1: Read data is registered. `rd_valid` is 1 in exactly the cycle after a read strobe and 0 in every other cycle, including after writes.
- R2: Offset 0x00 reads 0x00FF (flash write protection off) and offset 0x01 reads 0x1000 (boot flash size). Offset 0x0E reads 0x0021 (environment good). Offset 0x0C reads the chassis code in bits [7:5]; with the default code 4 this gives 0x0080.
- R3: Offset 0x05 reads the presence word. It starts as 0xFFFF. For each present slot n in 0..3, bits n, n+4, n+8 and n+12 are cleared.
- R4: Offset 0x0A is the 8-bit I/O mask. A write stores wdata[7:0], and a read returns it in bits [7:0] with zeros above. It resets to 0.
- R5: A write to offset 0x06 latches wdata[1:0] as `nm_slot` and drives the module EEPROM pins: chip select from bit 4, clock from bit 2, data-in from bit 6. A read returns the slot in [1:0], clock in bit 2, chip select in bit 4, data-in in bit 6 and the `nm_ee_do` pin in bit 7.
- R6: A write to offset 0x03 drives the mainboard EEPROM pins: chip select from bit 0, clock from bit 1, data-in from bit 2. A read returns those three in bits [2:0] and the `mb_ee_do` pin in bit 3.
- R7: A `mgmt_evt` pulse sets `mgmt_irq` from the next cycle onward. A read of offset 0x08 returns 0 and clears `mgmt_irq` in the cycle after the strobe. A new event in the strobe cycle takes priority over the clear.
- R8: An `ext_evt` pulse sets `ext_irq` from the next cycle onward. A read of offset 0x09 returns 0 and clears `ext_irq` in the cycle after the strobe, without touching `mgmt_irq`.
- R9: Offsets 0x10, 0x11, 0x12 and 0x13 read `net_irq_stat` bits [31:24], [23:16], [15:8] and [7:0] respectively, zero-extended. These bytes belong to slots 1, 0, 3 and 2.
- R10: Writes to the watchdog offset 0x02 or to any unmapped offset change no state. Reads of offset 0x02 and of unmapped offsets return 0.
- R11: After reset all EEPROM pins, `nm_slot`, the I/O mask, both interrupt requests and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 5 | Word offset |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| slot_present | input | 4 | Per-slot module present, active high |
| net_irq_stat | input | 32 | Network interrupt status vector |
| mgmt_evt | input | 1 | Management interrupt event |
| ext_evt | input | 1 | External interrupt event |
| mgmt_irq | output | 1 | Pending management interrupt |
| ext_irq | output | 1 | Pending external interrupt |
| mb_ee_cs | output | 1 | Mainboard EEPROM chip select |
| mb_ee_clk | output | 1 | Mainboard EEPROM clock |
| mb_ee_di | output | 1 | Mainboard EEPROM data into device |
| mb_ee_do | input | 1 | Mainboard EEPROM data out of device |
| nm_ee_cs | output | 1 | Module EEPROM chip select |
| nm_ee_clk | output | 1 | Module EEPROM clock |
| nm_ee_di | output | 1 | Module EEPROM data into device |
| nm_ee_do | input | 1 | Module EEPROM data out of device |
| nm_slot | output | 2 | Latched module EEPROM slot select |

## Verification
The bench drives an event in the same cycle as the acknowledge read. A design that let the clear win would drop that interrupt. It also checks that acknowledging one source leaves the other pending, which catches a shared clear. Presence patterns with no slots, all slots and alternate slots expose a wrong nibble replication or an inverted polarity. Each EEPROM pin is driven with a distinct bit, so a swapped clock and chip-select position shows up at the pins and in the readback. Writes to the watchdog and to unmapped offsets are followed by readback of the mask, the slot and the pins, which catches a decode that aliases them. The test also checks that `rd_valid` stays low after writes.

// File: rtl/ioc_regfile_pkg.sv
package ioc_regfile_pkg;

    localparam int unsigned OFF_W = 5;

    // Word offsets of the register map
    localparam logic [OFF_W-1:0] OFF_FLASH_WP  = 5'h00;
    localparam logic [OFF_W-1:0] OFF_BOOT_SIZE = 5'h01;
    localparam logic [OFF_W-1:0] OFF_WATCHDOG  = 5'h02;
    localparam logic [OFF_W-1:0] OFF_MB_EE     = 5'h03;
    localparam logic [OFF_W-1:0] OFF_PRESENCE  = 5'h05;
    localparam logic [OFF_W-1:0] OFF_NM_EE     = 5'h06;
    localparam logic [OFF_W-1:0] OFF_MGMT_ACK  = 5'h08;
    localparam logic [OFF_W-1:0] OFF_EXT_ACK   = 5'h09;
    localparam logic [OFF_W-1:0] OFF_IO_MASK   = 5'h0A;
    localparam logic [OFF_W-1:0] OFF_PLAT_ID   = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_ENV       = 5'h0E;
    localparam logic [OFF_W-1:0] OFF_NET_S1    = 5'h10;
    localparam logic [OFF_W-1:0] OFF_NET_S0    = 5'h11;
    localparam logic [OFF_W-1:0] OFF_NET_S3    = 5'h12;
    localparam logic [OFF_W-1:0] OFF_NET_S2    = 5'h13;

    // Fixed read values
    localparam logic [15:0] VAL_FLASH_WP  = 16'h00FF;
    localparam logic [15:0] VAL_BOOT_SIZE = 16'h1000;
    localparam logic [15:0] VAL_ENV       = 16'h0021;

    // Interrupt source indices
    localparam int unsigned IRQ_MGMT = 0;
    localparam int unsigned IRQ_EXT  = 1;
    localparam int unsigned IRQ_N    = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/ioc_bus_fsm.sv
module ioc_bus_fsm
    import ioc_regfile_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    bus_state_e state_q, state_d;

    // Next-state logic: TR_ACCEPT, TR_RETIRE, TR_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_strobe ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_strobe ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: capture read word on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_data <= '0;
        else if (rd_strobe) rd_data <= rd_word;
    end

    assign rd_valid = (state_q == ST_RESP);

    // R1: a read strobe is answered in the next cycle
    p_resp_follows_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_valid);
    // R1: no valid without a preceding read strobe
    p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> !rd_valid);
    // R1: captured data matches the word offered at the strobe
    p_data_captured_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (rd_data == $past(rd_word)));

endmodule

// File: rtl/ioc_irq_ack.sv
module ioc_irq_ack #(
    parameter int unsigned N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_evt,
    input  logic [N_SRC-1:0] ack_rd,
    output logic [N_SRC-1:0] pend
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)          pend[i] <= 1'b0;
            else if (set_evt[i]) pend[i] <= 1'b1;   // new event wins
            else if (ack_rd[i])  pend[i] <= 1'b0;
        end

        // R7 / R8: an event always leaves the request pending
        p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> pend[i]);
        // R8: acknowledge without event clears the request
        p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_rd[i] && !set_evt[i]) |=> !pend[i]);
        // R7: request holds when neither event nor acknowledge
        p_pend_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!ack_rd[i] && !set_evt[i]) |=> $stable(pend[i]));
    end

endmodule

// File: rtl/ioc_ee_pins.sv
module ioc_ee_pins #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned CS_BIT  = 0,
    parameter int unsigned CLK_BIT = 1,
    parameter int unsigned DI_BIT  = 2,
    parameter int unsigned DO_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ee_do,
    output logic              ee_cs,
    output logic              ee_clk,
    output logic              ee_di,
    output logic [DATA_W-1:0] rd_bits
);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ee_cs  <= 1'b0;
            ee_clk <= 1'b0;
            ee_di  <= 1'b0;
        end else if (wr) begin
            ee_cs  <= wdata[CS_BIT];
            ee_clk <= wdata[CLK_BIT];
            ee_di  <= wdata[DI_BIT];
        end
    end

    always_comb begin
        rd_bits          = '0;
        rd_bits[CS_BIT]  = ee_cs;
        rd_bits[CLK_BIT] = ee_clk;
        rd_bits[DI_BIT]  = ee_di;
        rd_bits[DO_BIT]  = ee_do;
    end

    // R5 / R6: pins follow the written bits
    p_pins_follow_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ee_cs == $past(wdata[CS_BIT])) && (ee_clk == $past(wdata[CLK_BIT]))
               && (ee_di == $past(wdata[DI_BIT])));
    // R10: pins hold without a write
    p_pins_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable({ee_cs, ee_clk, ee_di}));

endmodule

// File: rtl/ioc_regfile.sv
module ioc_regfile
    import ioc_regfile_pkg::*;
#(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned SLOTS        = 4,
    parameter int unsigned MASK_W       = 8,
    parameter int unsigned NET_W        = 32,
    parameter logic [2:0]  CHASSIS_CODE = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFF_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [SLOTS-1:0]  slot_present,
    input  logic [NET_W-1:0]  net_irq_stat,
    input  logic              mgmt_evt,
    input  logic              ext_evt,
    output logic              mgmt_irq,
    output logic              ext_irq,
    output logic              mb_ee_cs,
    output logic              mb_ee_clk,
    output logic              mb_ee_di,
    input  logic              mb_ee_do,
    output logic              nm_ee_cs,
    output logic              nm_ee_clk,
    output logic              nm_ee_di,
    input  logic              nm_ee_do,
    output logic [1:0]        nm_slot
);

    localparam int unsigned NIB_W   = 4;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned PLAT_LO = 5;

    logic rd_strobe, wr_strobe;
    assign rd_strobe = req_valid && !req_write;
    assign wr_strobe = req_valid &&  req_write;

    // ---------------- presence word (active low, one bit per slot per nibble)
    logic [DATA_W-1:0] presence;
    for (genvar b = 0; b < DATA_W; b++) begin : g_pres
        if ((b % NIB_W) < SLOTS) begin : g_slot
            assign presence[b] = ~slot_present[b % NIB_W];
        end else begin : g_empty
            assign presence[b] = 1'b1;
        end
    end

    // ---------------- I/O mask and module EEPROM slot select
    logic [MASK_W-1:0] io_mask_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                                     io_mask_q <= '0;
        else if (wr_strobe && req_addr == OFF_IO_MASK)  io_mask_q <= req_wdata[MASK_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                   nm_slot <= '0;
        else if (wr_strobe && req_addr == OFF_NM_EE)  nm_slot <= req_wdata[1:0];
    end

    // ---------------- EEPROM pin sets
    logic [DATA_W-1:0] mb_bits, nm_bits;

    ioc_ee_pins #(
        .DATA_W(DATA_W), .CS_BIT(0), .CLK_BIT(1), .DI_BIT(2), .DO_BIT(3)
    ) u_mb_ee (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_strobe && req_addr == OFF_MB_EE),
        .wdata(req_wdata), .ee_do(mb_ee_do),
        .ee_cs(mb_ee_cs), .ee_clk(mb_ee_clk), .ee_di(mb_ee_di),
        .rd_bits(mb_bits)
    );

    ioc_ee_pins #(
        .DATA_W(DATA_W), .CS_BIT(4), .CLK_BIT(2), .DI_BIT(6), .DO_BIT(7)
    ) u_nm_ee (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_strobe && req_addr == OFF_NM_EE),
        .wdata(req_wdata), .ee_do(nm_ee_do),
        .ee_cs(nm_ee_cs), .ee_clk(nm_ee_clk), .ee_di(nm_ee_di),
        .rd_bits(nm_bits)
    );

    // ---------------- clear-on-read interrupt requests
    logic [IRQ_N-1:0] irq_set, irq_ack, irq_pend;
    assign irq_set[IRQ_MGMT] = mgmt_evt;
    assign irq_set[IRQ_EXT]  = ext_evt;
    assign irq_ack[IRQ_MGMT] = rd_strobe && (req_addr == OFF_MGMT_ACK);
    assign irq_ack[IRQ_EXT]  = rd_strobe && (req_addr == OFF_EXT_ACK);

    ioc_irq_ack #(.N_SRC(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_evt(irq_set), .ack_rd(irq_ack), .pend(irq_pend)
    );
    assign mgmt_irq = irq_pend[IRQ_MGMT];
    assign ext_irq  = irq_pend[IRQ_EXT];

    // ---------------- read multiplexer
    logic [DATA_W-1:0] rd_word;
    logic              rd_hit;
    always_comb begin
        rd_word = '0;
        rd_hit  = 1'b1;
        unique case (req_addr)
            OFF_FLASH_WP:  rd_word = VAL_FLASH_WP;
            OFF_BOOT_SIZE: rd_word = VAL_BOOT_SIZE;
            OFF_WATCHDOG:  rd_word = '0;
            OFF_MB_EE:     rd_word = mb_bits;
            OFF_PRESENCE:  rd_word = presence;
            OFF_NM_EE:     rd_word = nm_bits | {{(DATA_W-2){1'b0}}, nm_slot};
            OFF_MGMT_ACK:  rd_word = '0;
            OFF_EXT_ACK:   rd_word = '0;
            OFF_IO_MASK:   rd_word = {{(DATA_W-MASK_W){1'b0}}, io_mask_q};
            OFF_PLAT_ID:   rd_word = {{(DATA_W-PLAT_LO-3){1'b0}}, CHASSIS_CODE, {PLAT_LO{1'b0}}};
            OFF_ENV:       rd_word = VAL_ENV;
            OFF_NET_S1:    rd_word = {{(DATA_W-BYTE_W){1'b0}}, net_irq_stat[31:24]};
            OFF_NET_S0:    rd_word = {{(DATA_W-BYTE_W){1'b0}}, net_irq_stat[23:16]};
            OFF_NET_S3:    rd_word = {{(DATA_W-BYTE_W){1'b0}}, net_irq_stat[15:8]};
            OFF_NET_S2:    rd_word = {{(DATA_W-BYTE_W){1'b0}}, net_irq_stat[7:0]};
            default: begin
                rd_word = '0;
                rd_hit  = 1'b0;
            end
        endcase
    end

    ioc_bus_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rd_strobe(rd_strobe), .rd_word(rd_word),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // R10: reads outside the map return zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rd_hit) |=> (rd_data == '0));
    // R4: mask takes the written low byte
    p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && req_addr == OFF_IO_MASK) |=> (io_mask_q == $past(req_wdata[MASK_W-1:0])));
    // R5: slot select latched on a module EEPROM write
    p_slot_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && req_addr == OFF_NM_EE) |=> (nm_slot == $past(req_wdata[1:0])));
    // R7: acknowledge reads return zero
    p_ack_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack) |=> (rd_data == '0));

endmodule

// File: tb/ioc_regfile_tb.sv
module ioc_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [3:0]  slot_present = 4'b0101;
    logic [31:0] net_irq_stat = 32'hA1B2C3D4;
    logic        mgmt_evt = 1'b0, ext_evt = 1'b0;
    logic        mgmt_irq, ext_irq;
    logic        mb_ee_cs, mb_ee_clk, mb_ee_di, mb_ee_do = 1'b0;
    logic        nm_ee_cs, nm_ee_clk, nm_ee_di, nm_ee_do = 1'b0;
    logic [1:0]  nm_slot;

    int total = 0;
    int bad   = 0;

    always #5ns clk = ~clk;

    ioc_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .slot_present(slot_present), .net_irq_stat(net_irq_stat),
        .mgmt_evt(mgmt_evt), .ext_evt(ext_evt),
        .mgmt_irq(mgmt_irq), .ext_irq(ext_irq),
        .mb_ee_cs(mb_ee_cs), .mb_ee_clk(mb_ee_clk), .mb_ee_di(mb_ee_di), .mb_ee_do(mb_ee_do),
        .nm_ee_cs(nm_ee_cs), .nm_ee_clk(nm_ee_clk), .nm_ee_di(nm_ee_di), .nm_ee_do(nm_ee_do),
        .nm_slot(nm_slot)
    );

    // {offset, expected read}; present=0101, net status A1B2C3D4
    localparam int NVEC = 12;
    localparam logic [20:0] VEC [NVEC] = '{
        {5'h00, 16'h00FF},   // R2 flash protect
        {5'h01, 16'h1000},   // R2 boot size
        {5'h0E, 16'h0021},   // R2 environment
        {5'h0C, 16'h0080},   // R2 platform code 4
        {5'h05, 16'hAAAA},   // R3 slots 0 and 2 present
        {5'h10, 16'h00A1},   // R9 slot 1 byte
        {5'h11, 16'h00B2},   // R9 slot 0 byte
        {5'h12, 16'h00C3},   // R9 slot 3 byte
        {5'h13, 16'h00D4},   // R9 slot 2 byte
        {5'h02, 16'h0000},   // R10 watchdog reads 0
        {5'h1F, 16'h0000},   // R10 unmapped
        {5'h07, 16'h0000}    // R10 unmapped
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [15:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    initial begin
        #2_000_000ns;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic        v;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset outputs",
            {rd_valid, mgmt_irq, ext_irq, mb_ee_cs, mb_ee_clk, mb_ee_di,
             nm_ee_cs, nm_ee_clk, nm_ee_di, nm_slot}, '0);
        rst_n = 1'b1;
        do_read(5'h0A, d, v);
        chk("R11 mask reset", d, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            do_read(VEC[i][20:16], d, v);
            chk($sformatf("vector %0d (R2 R3 R9 R10)", i), d, VEC[i][15:0]);
            chk("R1 valid after read", v, 1'b1);
        end
        @(negedge clk);
        chk("R1 valid drops", rd_valid, 1'b0);

        // R3 presence corners
        slot_present = 4'b1111;
        do_read(5'h05, d, v);
        chk("R3 all present", d, 16'h0000);
        slot_present = 4'b0000;
        do_read(5'h05, d, v);
        chk("R3 none present", d, 16'hFFFF);

        // R4 mask
        do_write(5'h0A, 16'hABCD);
        chk("R1 no valid after write", rd_valid, 1'b0);
        do_read(5'h0A, d, v);
        chk("R4 mask low byte", d, 16'h00CD);

        // R5 module EEPROM
        do_write(5'h06, 16'h00D7);
        chk("R5 slot", nm_slot, 2'd3);
        chk("R5 pins cs clk di", {nm_ee_cs, nm_ee_clk, nm_ee_di}, 3'b111);
        nm_ee_do = 1'b1;
        do_read(5'h06, d, v);
        chk("R5 readback", d, 16'h00D7);
        do_write(5'h06, 16'h0012);
        chk("R5 slot 2 cs only", {nm_slot, nm_ee_cs, nm_ee_clk, nm_ee_di}, 5'b10100);
        nm_ee_do = 1'b0;
        do_read(5'h06, d, v);
        chk("R5 readback 2", d, 16'h0012);

        // R6 mainboard EEPROM
        do_write(5'h03, 16'h0005);
        chk("R6 pins cs clk di", {mb_ee_cs, mb_ee_clk, mb_ee_di}, 3'b101);
        mb_ee_do = 1'b1;
        do_read(5'h03, d, v);
        chk("R6 readback", d, 16'h000D);

        // R10 writes to watchdog / unmapped change nothing
        do_write(5'h02, 16'h7D00);
        do_write(5'h1F, 16'hFFFF);
        do_write(5'h07, 16'hFFFF);
        do_read(5'h0A, d, v);
        chk("R10 mask unchanged", d, 16'h00CD);
        chk("R10 pins unchanged",
            {nm_slot, nm_ee_cs, nm_ee_clk, nm_ee_di, mb_ee_cs, mb_ee_clk, mb_ee_di},
            8'b10100101);

        // R7 management interrupt
        @(negedge clk); mgmt_evt = 1'b1;
        @(negedge clk); mgmt_evt = 1'b0;
        chk("R7 mgmt set", mgmt_irq, 1'b1);
        // R8 external interrupt
        @(negedge clk); ext_evt = 1'b1;
        @(negedge clk); ext_evt = 1'b0;
        chk("R8 ext set", ext_irq, 1'b1);
        do_read(5'h09, d, v);
        chk("R8 ext ack reads 0", d, 16'h0000);
        chk("R8 ext cleared", ext_irq, 1'b0);
        chk("R8 mgmt untouched", mgmt_irq, 1'b1);
        // R7 event in the acknowledge cycle wins
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 5'h08; mgmt_evt = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; mgmt_evt = 1'b0;
        chk("R7 set wins over ack", mgmt_irq, 1'b1);
        chk("R7 ack reads 0", rd_data, 16'h0000);
        do_read(5'h08, d, v);
        chk("R7 mgmt cleared", mgmt_irq, 1'b0);
        chk("R7 ack reads 0 again", d, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule